// File: doc/BRIEF.md
# Boundary-Scan Interconnect Test Engine

This engine tests the nets that join two scan-capable devices. Their boundary registers form one serial chain. The driving device's cells come first and the receiving device's cells come last, so the chain is 2N cells long. The engine first proves that the chain shifts cleanly. It then runs a fixed set of stimulus patterns. For each pattern it shifts the stimulus into the driving cells and applies it to the nets. The receiving cells capture the net values, and the engine shifts the captured word out while it loads the next stimulus. Each net whose observed value ever differs from the expected value is recorded in a sticky failure mask. Each failing net is also given a fault class.

For simulation, the block contains a net fault model. It can inject a wired-AND short between two nets, an open net, a net stuck at 0, and a break in the serial link between the two devices. A test run starts with a one-cycle `start` in the idle state. It ends with a one-cycle `done`, after which the pass flag, the chain-error flag, the mask and the classes stay valid until the next start.

The controller uses six states:

- `S_IDLE` goes to `S_CHAIN` on `start`.
- `S_CHAIN` does the integrity shift. It goes to `S_DONE` on the first mismatch, or to `S_SHIFT` after its last cycle.
- `S_SHIFT` unloads the previous capture and loads the next stimulus over 2N cycles. It then goes to `S_UPDATE`, or to `S_DONE` once every pattern has been captured.
- `S_UPDATE` drives the stimulus onto the nets and goes to `S_CAPTURE`.
- `S_CAPTURE` samples the nets and returns to `S_SHIFT`.
- `S_DONE` raises `done` and returns to `S_IDLE`.

Top module: `bscan_ic_tester`

## Requirements
- R1: After reset, `done`, `pass` and `chain_err` are 0, and `fail_mask` and `fail_class` are all zero.
- R2: A run begins with an integrity shift of 2N+4 cycles. The serial input carries the repeating sequence 1,1,0,0. From cycle 2N on, the chain output must repeat the input from 2N cycles earlier. On a mismatch the run aborts within 2N+4 cycles of the start edge. It then ends with `chain_err`=1, `pass`=0, and an all-zero mask and classes, and no interconnect pattern is applied.
- R3: There are W=$clog2(N+1)+1 true patterns. In true pattern p, net i carries bit p of the code i+1. These are followed by W patterns that are the bitwise complements of the true patterns, so 2W patterns are applied in all.
- R4: An injected short between nets a and b makes both nets carry the AND of their two driven values.
- R5: An injected open net is read as 1, and an injected stuck net is read as 0. The open fault takes precedence over the stuck fault, and the stuck fault takes precedence over the short.
- R6: Bit i of `fail_mask` is 1 exactly when net i read a wrong value in at least one pattern of the run. Mask bits never clear during a run, and a start accepted in idle clears them.
- R7: Each net has a 2-bit class at `fail_class[2i+1:2i]`, with these codes:
  - 0 means no failure.
  - 1 (stuck) means the net failed and only ever read 0.
  - 3 (open) means the net failed and only ever read 1.
  - 2 (bridge) means the net failed and read both values.
- R8: `done` is high for exactly one cycle. `pass` is 1 only when no chain error occurred and the mask is all zero.
- R9: A run that passes the integrity shift raises `done` exactly 2N+4 + 2W(2N+2) + 2N cycles after the start edge. With no fault injected, that run passes.
- R10: A `start` seen while a run is in progress has no effect. Neither the run's length nor its results change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the engine is idle |
| flt_short_en | input | 1 | Enables the short between two nets |
| flt_short_a | input | NET_IW | First net of the short |
| flt_short_b | input | NET_IW | Second net of the short |
| flt_open_en | input | 1 | Enables the open fault |
| flt_open_net | input | NET_IW | Net that is open |
| flt_stuck_en | input | 1 | Enables the stuck-at-0 fault |
| flt_stuck_net | input | NET_IW | Net that is stuck at 0 |
| flt_chain_break | input | 1 | Breaks the serial link between the devices, which then reads 1 |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | The run found no fault |
| chain_err | output | 1 | The integrity shift failed and the run was aborted |
| fail_mask | output | N_NETS | Sticky per-net failure flags |
| fail_class | output | 2*N_NETS | Per-net fault class, 2 bits per net |

## Verification
The bench targets the following cases:

- Shorts between nets whose codes are complements, such as nets 6 and 7. A design that drops the extra code bit would see those nets read 0 in every pattern and misclass them as stuck instead of bridge.
- Shorts of a net with itself. A design that flags these would report a false failure.
- Open, stuck and short faults placed on the same net. These expose a wrong precedence as a wrong class or mask.
- A broken serial link combined with net faults. A design that does not abort would report net failures or the full run length instead of a clean `chain_err`.
- A second start pulse in the middle of a run. A design that restarts on it would lengthen the run.
- Random fault mixes, which catch errors in the pattern bit ordering and in the unload shift order as wrong mask bits.

// File: rtl/bscan_ic_pkg.sv
package bscan_ic_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHAIN,
        S_SHIFT,
        S_UPDATE,
        S_CAPTURE,
        S_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_STUCK  = 2'd1,
        CLS_BRIDGE = 2'd2,
        CLS_OPEN   = 2'd3
    } net_class_t;

    // Value that net 'net' carries in pattern 'pat' given code width 'w':
    // true patterns carry bit pat of (net+1), later ones the complement.
    function automatic logic pattern_bit(input int unsigned pat,
                                         input int unsigned net,
                                         input int unsigned w);
        int unsigned code;
        code = net + 1;
        if (pat < w)
            return ((code >> pat) & 1) != 0;
        else
            return ((code >> (pat - w)) & 1) == 0;
    endfunction

endpackage

// File: rtl/bscan_pair_model.sv
module bscan_pair_model #(
    parameter int N_NETS = 8,
    parameter int NET_IW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              capture_en,
    input  logic              scan_in,
    input  logic              link_break,
    input  logic              short_en,
    input  logic [NET_IW-1:0] short_a,
    input  logic [NET_IW-1:0] short_b,
    input  logic              open_en,
    input  logic [NET_IW-1:0] open_net,
    input  logic              stuck_en,
    input  logic [NET_IW-1:0] stuck_net,
    output logic              scan_out
);

    logic [N_NETS-1:0] drv_sr;
    logic [N_NETS-1:0] drv_hold;
    logic [N_NETS-1:0] rcv_sr;
    logic [N_NETS-1:0] net_val;
    logic              link_bit;
    logic              and_val;

    assign link_bit = link_break ? 1'b1 : drv_sr[0];
    assign scan_out = rcv_sr[0];

    // Fault model: short first, then stuck-at-0, then open wins.
    always_comb begin
        net_val = drv_hold;
        and_val = 1'b1;
        if (short_en && (32'(short_a) < N_NETS) && (32'(short_b) < N_NETS)) begin
            and_val          = drv_hold[short_a] & drv_hold[short_b];
            net_val[short_a] = and_val;
            net_val[short_b] = and_val;
        end
        if (stuck_en && (32'(stuck_net) < N_NETS))
            net_val[stuck_net] = 1'b0;
        if (open_en && (32'(open_net) < N_NETS))
            net_val[open_net] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_sr   <= '0;
            drv_hold <= '0;
            rcv_sr   <= '0;
        end else begin
            if (shift_en) begin
                drv_sr <= {scan_in, drv_sr[N_NETS-1:1]};
                rcv_sr <= {link_bit, rcv_sr[N_NETS-1:1]};
            end else if (capture_en) begin
                rcv_sr <= net_val;
            end
            if (update_en)
                drv_hold <= drv_sr;
        end
    end

endmodule

// File: rtl/bscan_fault_classifier.sv
module bscan_fault_classifier
    import bscan_ic_pkg::*;
#(
    parameter int N_NETS = 8
) (
    input  logic [N_NETS-1:0]   fail_mask,
    input  logic [N_NETS-1:0]   saw_one,
    input  logic [N_NETS-1:0]   saw_zero,
    output logic [2*N_NETS-1:0] fail_class
);

    for (genvar i = 0; i < N_NETS; i++) begin : g_net
        net_class_t cls;
        always_comb begin
            if (!fail_mask[i])
                cls = CLS_NONE;
            else if (saw_zero[i] && !saw_one[i])
                cls = CLS_STUCK;
            else if (saw_one[i] && !saw_zero[i])
                cls = CLS_OPEN;
            else
                cls = CLS_BRIDGE;
        end
        assign fail_class[2*i +: 2] = cls;
    end

endmodule

// File: rtl/bscan_ic_fsm.sv
module bscan_ic_fsm
    import bscan_ic_pkg::*;
#(
    parameter int N_NETS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              scan_out,
    output logic              shift_en,
    output logic              update_en,
    output logic              capture_en,
    output logic              scan_in,
    output logic              done,
    output logic              pass,
    output logic              chain_err,
    output logic [N_NETS-1:0] fail_mask,
    output logic [N_NETS-1:0] saw_one,
    output logic [N_NETS-1:0] saw_zero
);

    localparam int CODE_W    = $clog2(N_NETS + 1) + 1;
    localparam int NUM_PAT   = 2 * CODE_W;
    localparam int CHAIN_LEN = 2 * N_NETS;
    localparam int CHK_LEN   = CHAIN_LEN + 4;
    localparam int CNT_W     = $clog2(CHK_LEN + 1);
    localparam int PAT_W     = $clog2(NUM_PAT + 1);

    localparam logic [CNT_W-1:0] CHK_LAST   = CNT_W'(CHK_LEN - 1);
    localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(CHAIN_LEN - 1);
    localparam logic [CNT_W-1:0] CHAIN_L    = CNT_W'(CHAIN_LEN);
    localparam logic [CNT_W-1:0] NETS_C     = CNT_W'(N_NETS);
    localparam logic [PAT_W-1:0] PAT_END    = PAT_W'(NUM_PAT);

    eng_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [PAT_W-1:0]  pat_q;
    logic [CNT_W-1:0]  chain_off;
    logic              chain_bad;
    logic              cmp_en;
    logic              cmp_exp;
    logic              shift_last;

    assign chain_off  = cnt_q - CHAIN_L;
    assign chain_bad  = (state_q == S_CHAIN) && (cnt_q >= CHAIN_L)
                        && (scan_out != ~chain_off[1]);
    assign cmp_en     = (state_q == S_SHIFT) && (pat_q != '0) && (cnt_q < NETS_C);
    assign cmp_exp    = pattern_bit(32'(pat_q) - 1, 32'(cnt_q), CODE_W);
    assign shift_last = (cnt_q == SHIFT_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_CHAIN;
            S_CHAIN:   if (chain_bad)             state_d = S_DONE;
                       else if (cnt_q == CHK_LAST) state_d = S_SHIFT;
            S_SHIFT:   if (shift_last) state_d = (pat_q == PAT_END) ? S_DONE : S_UPDATE;
            S_UPDATE:  state_d = S_CAPTURE;
            S_CAPTURE: state_d = S_SHIFT;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Chain controls
    always_comb begin
        shift_en   = (state_q == S_CHAIN) || (state_q == S_SHIFT);
        update_en  = (state_q == S_UPDATE);
        capture_en = (state_q == S_CAPTURE);
        done       = (state_q == S_DONE);
        scan_in    = 1'b0;
        if (state_q == S_CHAIN)
            scan_in = ~cnt_q[1];
        else if (state_q == S_SHIFT && cnt_q >= NETS_C && pat_q < PAT_END)
            scan_in = pattern_bit(32'(pat_q), 32'(cnt_q) - N_NETS, CODE_W);
    end

    // Outputs and run state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pat_q     <= '0;
            pass      <= 1'b0;
            chain_err <= 1'b0;
            fail_mask <= '0;
            saw_one   <= '0;
            saw_zero  <= '0;
        end else begin
            if (state_d != state_q) cnt_q <= '0;
            else if (shift_en)      cnt_q <= cnt_q + 1'b1;

            if (state_q == S_IDLE && start) begin
                pat_q     <= '0;
                pass      <= 1'b0;
                chain_err <= 1'b0;
                fail_mask <= '0;
                saw_one   <= '0;
                saw_zero  <= '0;
            end
            if (state_q == S_CAPTURE) pat_q <= pat_q + 1'b1;
            if (chain_bad) chain_err <= 1'b1;
            if (cmp_en) begin
                for (int i = 0; i < N_NETS; i++) begin
                    if (cnt_q == CNT_W'(i)) begin
                        if (scan_out != cmp_exp) fail_mask[i] <= 1'b1;
                        if (scan_out) saw_one[i]  <= 1'b1;
                        else          saw_zero[i] <= 1'b1;
                    end
                end
            end
            if (state_q == S_SHIFT && shift_last && pat_q == PAT_END && fail_mask == '0)
                pass <= 1'b1;
        end
    end

endmodule

// File: rtl/bscan_ic_tester.sv
module bscan_ic_tester #(
    parameter int N_NETS = 8,
    parameter int NET_IW = (N_NETS > 1) ? $clog2(N_NETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                flt_short_en,
    input  logic [NET_IW-1:0]   flt_short_a,
    input  logic [NET_IW-1:0]   flt_short_b,
    input  logic                flt_open_en,
    input  logic [NET_IW-1:0]   flt_open_net,
    input  logic                flt_stuck_en,
    input  logic [NET_IW-1:0]   flt_stuck_net,
    input  logic                flt_chain_break,
    output logic                done,
    output logic                pass,
    output logic                chain_err,
    output logic [N_NETS-1:0]   fail_mask,
    output logic [2*N_NETS-1:0] fail_class
);

    logic              shift_en, update_en, capture_en;
    logic              scan_in, scan_out;
    logic [N_NETS-1:0] saw_one, saw_zero;

    bscan_ic_fsm #(.N_NETS(N_NETS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .scan_out   (scan_out),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .capture_en (capture_en),
        .scan_in    (scan_in),
        .done       (done),
        .pass       (pass),
        .chain_err  (chain_err),
        .fail_mask  (fail_mask),
        .saw_one    (saw_one),
        .saw_zero   (saw_zero)
    );

    bscan_pair_model #(.N_NETS(N_NETS), .NET_IW(NET_IW)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .capture_en (capture_en),
        .scan_in    (scan_in),
        .link_break (flt_chain_break),
        .short_en   (flt_short_en),
        .short_a    (flt_short_a),
        .short_b    (flt_short_b),
        .open_en    (flt_open_en),
        .open_net   (flt_open_net),
        .stuck_en   (flt_stuck_en),
        .stuck_net  (flt_stuck_net),
        .scan_out   (scan_out)
    );

    bscan_fault_classifier #(.N_NETS(N_NETS)) u_cls (
        .fail_mask  (fail_mask),
        .saw_one    (saw_one),
        .saw_zero   (saw_zero),
        .fail_class (fail_class)
    );

endmodule

// File: rtl/bscan_ic_checker.sv
module bscan_ic_checker #(
    parameter int N_NETS = 8,
    parameter int NET_IW = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic                pass,
    input logic                chain_err,
    input logic [N_NETS-1:0]   fail_mask,
    input logic [2*N_NETS-1:0] fail_class,
    input logic                flt_open_en,
    input logic [NET_IW-1:0]   flt_open_net
);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_pass_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (fail_mask == '0 && !chain_err));

    p_mask_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (($past(fail_mask) & ~fail_mask) == '0));

    p_abort_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chain_err) |-> (fail_mask == '0 && !pass));

    p_open_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !chain_err && flt_open_en && 32'(flt_open_net) < N_NETS)
        |-> (fail_class[2*flt_open_net +: 2] == 2'd3));

    for (genvar i = 0; i < N_NETS; i++) begin : g_cls
        p_class_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> ((fail_class[2*i +: 2] != 2'd0) == fail_mask[i]));
    end

endmodule

bind bscan_ic_tester bscan_ic_checker #(.N_NETS(N_NETS), .NET_IW(NET_IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .done         (done),
    .pass         (pass),
    .chain_err    (chain_err),
    .fail_mask    (fail_mask),
    .fail_class   (fail_class),
    .flt_open_en  (flt_open_en),
    .flt_open_net (flt_open_net)
);

// File: tb/tb_bscan_ic_tester.sv
module tb_bscan_ic_tester;

    localparam int N      = 8;
    localparam int IW     = 3;
    localparam int W      = $clog2(N + 1) + 1;
    localparam int NPAT   = 2 * W;
    localparam int RUNLEN = 2*N + 4 + NPAT*(2*N + 2) + 2*N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sh_en = 1'b0, op_en = 1'b0, st_en = 1'b0, brk = 1'b0;
    logic [IW-1:0] sh_a = '0, sh_b = '0, op_n = '0, st_n = '0;
    logic          done, pass, chain_err;
    logic [N-1:0]  fail_mask;
    logic [2*N-1:0] fail_class;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bscan_ic_tester #(.N_NETS(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .flt_short_en(sh_en), .flt_short_a(sh_a), .flt_short_b(sh_b),
        .flt_open_en(op_en), .flt_open_net(op_n),
        .flt_stuck_en(st_en), .flt_stuck_net(st_n),
        .flt_chain_break(brk),
        .done(done), .pass(pass), .chain_err(chain_err),
        .fail_mask(fail_mask), .fail_class(fail_class)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic pbit(int p, int i);
        int code = i + 1;
        if (p < W) return ((code >> p) & 1) != 0;
        return ((code >> (p - W)) & 1) == 0;
    endfunction

    // Net readings under the fault rules of R4 and R5
    function automatic logic [N-1:0] faulty(logic [N-1:0] d);
        logic [N-1:0] r = d;
        logic a;
        if (sh_en) begin
            a = d[sh_a] & d[sh_b];
            r[sh_a] = a;
            r[sh_b] = a;
        end
        if (st_en) r[st_n] = 1'b0;
        if (op_en) r[op_n] = 1'b1;
        return r;
    endfunction

    task automatic run_case(input string name, input bit restart_mid);
        logic [N-1:0] d, r, emask, s1, s0;
        logic [2*N-1:0] ecls;
        int k;
        bit seen;
        emask = '0; s1 = '0; s0 = '0; ecls = '0;
        for (int p = 0; p < NPAT; p++) begin
            for (int i = 0; i < N; i++) d[i] = pbit(p, i);
            r = faulty(d);
            for (int i = 0; i < N; i++) begin
                if (r[i] != d[i]) emask[i] = 1'b1;
                if (r[i]) s1[i] = 1'b1; else s0[i] = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (emask[i]) ecls[2*i +: 2] = (s0[i] && !s1[i]) ? 2'd1 : (s1[i] && !s0[i]) ? 2'd3 : 2'd2;
        end
        if (brk) begin emask = '0; ecls = '0; end

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        k = 0;
        seen = done;
        while (!seen && k < RUNLEN + 50) begin
            @(negedge clk);
            k++;
            if (restart_mid && k == 40) start = 1'b1;
            if (restart_mid && k == 41) start = 1'b0;
            seen = done;
        end
        if (!seen) begin
            chk(0, {name, " watchdog R9"}, k, RUNLEN);
            return;
        end
        if (brk) begin
            chk(k <= 2*N + 4, {name, " R2 abort latency"}, k, 2*N + 4);
            chk(chain_err == 1'b1, {name, " R2 chain_err"}, chain_err, 1);
        end else begin
            chk(k == RUNLEN, {name, " R9/R10 run length"}, k, RUNLEN);
            chk(chain_err == 1'b0, {name, " R2 no chain_err"}, chain_err, 0);
        end
        chk(fail_mask == emask, {name, " R3/R4/R5/R6 mask"}, fail_mask, emask);
        chk(fail_class == ecls, {name, " R7 class"}, fail_class, ecls);
        chk(pass == (!brk && emask == '0), {name, " R8 pass"}, pass, (!brk && emask == '0));
        @(negedge clk);
        chk(done == 1'b0, {name, " R8 single done"}, done, 0);
        chk(fail_mask == emask && pass == (!brk && emask == '0), {name, " R6/R8 hold"}, fail_mask, emask);
    endtask

    task automatic clear_faults();
        sh_en = 0; op_en = 0; st_en = 0; brk = 0;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(done == 0 && pass == 0 && chain_err == 0, "R1 reset flags", {done, pass, chain_err}, 0);
        chk(fail_mask == '0 && fail_class == '0, "R1 reset mask", fail_mask, 0);
        rst_n = 1'b1;
        @(negedge clk);

        clear_faults();
        run_case("R9 clean", 0);
        sh_en = 1; sh_a = 3'd6; sh_b = 3'd7;
        run_case("R4 complement short", 0);
        sh_a = 3'd2; sh_b = 3'd2;
        run_case("R4 self short", 0);
        clear_faults(); op_en = 1; op_n = 3'd0;
        run_case("R5 open", 0);
        clear_faults(); st_en = 1; st_n = 3'd5;
        run_case("R5 stuck", 0);
        clear_faults(); sh_en = 1; sh_a = 3'd1; sh_b = 3'd4; st_en = 1; st_n = 3'd1; op_en = 1; op_n = 3'd1;
        run_case("R5 precedence", 0);
        clear_faults(); sh_en = 1; sh_a = 3'd0; sh_b = 3'd3;
        run_case("R10 restart mid-run", 1);
        brk = 1; op_en = 1; op_n = 3'd2;
        run_case("R2 link break", 0);
        clear_faults();
        run_case("R6 clear after abort", 0);

        for (int t = 0; t < 24; t++) begin
            sh_en = 1'($urandom_range(0, 1)); sh_a = IW'($urandom_range(0, N-1)); sh_b = IW'($urandom_range(0, N-1));
            op_en = 1'($urandom_range(0, 1)); op_n = IW'($urandom_range(0, N-1));
            st_en = 1'($urandom_range(0, 1)); st_n = IW'($urandom_range(0, N-1));
            brk   = ($urandom_range(0, 7) == 0);
            run_case($sformatf("rand%0d R3", t), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule